// File: doc/BRIEF.md
# Receive Elasticity Buffer with Fill Insertion and Framing Deletion

This block sits in a serial receive channel between the recovered clock, which writes decoded characters, and a local read clock that may differ in frequency and phase. Each stored word is 11 bits: an 8-bit decoded character in bits [7:0] and three status bits in bits [10:8]. The framing character is the word `11'h1BC` (status `3'b001`, character `8'hBC`, the K28.5 comma). To absorb the rate difference, the write side discards an incoming framing character when the buffer runs high. The read side emits an extra framing character, without consuming a stored entry, when the buffer runs low. Either adjustment happens only while a framing character is involved: the one being dropped, or one held in the buffer.

Pointers cross domains in Gray code through two-flop synchronisers. They count modulo twice the depth, so that full and empty can be told apart. The 20 pointer states map onto a contiguous run of a 5-bit reflected Gray code, which keeps every step a single-bit change, the wrap included. A running count of framing words written is carried to the read side in the same way. Each domain has a small state machine whose state records the action taken on the last edge. Write side: `WS_HOLD` (reset or bypass), `WS_STORE`, `WS_DROP` and `WS_RECENTRE`. Read side: `RS_HOLD`, `RS_FETCH`, `RS_FILL` and `RS_RECENTRE`. Every edge chooses the next state from the current inputs, in priority order. Write side: bypass → `WS_HOLD`; framing word in with fill ≥ 8 → `WS_DROP`; fill = 10 → `WS_RECENTRE`; otherwise `WS_STORE`. Read side: bypass → `RS_HOLD`; fill ≤ 2 with a framing word held → `RS_FILL`; fill = 0 → `RS_RECENTRE`; otherwise `RS_FETCH`.

When the output is clocked from the recovered clock, the `bypass` input routes the write data, registered once on the write clock, straight to the output. The buffer then neither inserts nor deletes.

Top module: `rx_elastic_buf`

## Requirements
- R1: Apart from dropped and inserted framing words, the words leave on `rd_data` in the order they entered on `wr_data`. The buffer holds 10 entries of 11 bits, each {status[10:8], char[7:0]}.
- R2: While `rst_n` is low, `rd_ins`, `wr_del`, `wr_err` and `rd_err` are 0 and `rd_data` is the framing word `11'h1BC`. Reset places the write pointer 5 entries ahead of the read pointer, with those 5 entries holding framing words, so the first 5 words read after reset are framing words.
- R3: When the write-side fill level is 8 or more, an incoming framing word is discarded. `wr_del` is then high for the one write-clock cycle after the edge that sampled it.
- R4: Only framing words are ever discarded. When no framing word arrives, `wr_del` never rises.
- R5: When the read-side fill level is 2 or less and a framing word is held in the buffer, the read side outputs `11'h1BC` without advancing its pointer. `rd_ins` is high in the same read-clock cycle that this word is on `rd_data`.
- R6: `rd_ins` rises only while at least one framing word is stored in the buffer.
- R7: A write into a buffer seen as full sets the sticky `wr_err` and places the write pointer 5 entries ahead of the synchronised read pointer. While fill stays inside the limits, `wr_err` stays 0.
- R8: A read from a buffer seen as empty, with no framing word to insert, sets the sticky `rd_err`, outputs `11'h1BC`, and places the read pointer 5 entries behind the synchronised write pointer. While fill stays inside the limits, `rd_err` stays 0.
- R9: With `bypass` high, `rd_data` equals the `wr_data` sampled at the previous write-clock edge, and `rd_ins` and `wr_del` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock, write domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_data | input | 11 | Decoded word {status, char} written each write cycle |
| rd_clk | input | 1 | Local read clock |
| bypass | input | 1 | 1: output follows the write side, no buffering |
| rd_data | output | 11 | Word presented each read cycle |
| rd_ins | output | 1 | Pulse: current `rd_data` is an inserted framing word |
| wr_del | output | 1 | Pulse: the last sampled framing word was discarded |
| wr_err | output | 1 | Sticky overflow flag, write domain |
| rd_err | output | 1 | Sticky underflow flag, read domain |

## Verification
The bench runs the write clock equal to, faster than and slower than the 200 MHz read clock. Framing words are either sprinkled through the stream or absent entirely, so that deletion, insertion, overflow and underflow each come into play. A design that dropped or inserted in the wrong place would reorder or lose data words, and the queue model would catch the mismatch. One that inserted with no framing word stored would trip the model's framing-presence check. One that deleted a data word would show `wr_del` against a non-framing word. With framing words withheld, a wrong full or empty test shows up as a missing sticky error. Bypass mode is checked for its one-cycle pass-through and for silent flags.

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;

    localparam int CHAR_W = 8;
    localparam int STAT_W = 3;
    localparam int WORD_W = CHAR_W + STAT_W;

    typedef logic [WORD_W-1:0] word_t;

    // framing / fill word: status 001, character K28.5 code 0xBC
    localparam word_t FILL_WORD = {3'b001, 8'hBC};

    typedef enum logic [1:0] {
        WS_HOLD,
        WS_STORE,
        WS_DROP,
        WS_RECENTRE
    } wr_state_e;

    typedef enum logic [1:0] {
        RS_HOLD,
        RS_FETCH,
        RS_FILL,
        RS_RECENTRE
    } rd_state_e;

    function automatic logic [7:0] bin2gray(input logic [7:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [7:0] gray2bin(input logic [7:0] g);
        logic [7:0] b;
        b[7] = g[7];
        for (int i = 6; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/rxeb_sync.sv
module rxeb_sync #(
    parameter int              W       = 5,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/rxeb_store.sv
module rxeb_store
    import rxeb_pkg::*;
#(
    parameter int DEPTH = 10,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t ent [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                ent[e] <= FILL_WORD;
            end
        end else if (we) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (waddr == AW'(e)) begin
                    ent[e] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = FILL_WORD;
        for (int e = 0; e < DEPTH; e++) begin
            if (raddr == AW'(e)) begin
                rdata = ent[e];
            end
        end
    end

endmodule

// File: rtl/rxeb_wr_ctl.sv
module rxeb_wr_ctl
    import rxeb_pkg::*;
#(
    parameter int DEPTH   = 10,
    parameter int MID     = 5,
    parameter int HI_MARK = 8,
    parameter int PW      = 5,
    parameter int FCW     = 5,
    localparam int AW     = $clog2(DEPTH),
    localparam int TWO_D  = 2 * DEPTH,
    localparam int GOFS   = (1 << (PW - 1)) - DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bypass,
    input  word_t         din,
    input  logic [PW-1:0] rp_gray_s,
    output logic [PW-1:0] wp_gray,
    output logic [FCW-1:0] frm_gray,
    output logic          we,
    output logic [AW-1:0] waddr,
    output word_t         wdata,
    output logic          del_pulse,
    output logic          ovf_err
);

    function automatic logic [PW-1:0] ptr2g(input logic [PW-1:0] p);
        logic [7:0] t;
        t = bin2gray(8'(32'(p) + 32'(GOFS)));
        return t[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] g2ptr(input logic [PW-1:0] g);
        logic [7:0] t;
        t = gray2bin(8'(g));
        return PW'(32'(t) - 32'(GOFS));
    endfunction

    function automatic logic [PW-1:0] ptr_add(input logic [PW-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= TWO_D) s = s - TWO_D;
        if (s < 0)      s = s + TWO_D;
        return PW'(s);
    endfunction

    wr_state_e      state, nxt;
    logic [PW-1:0]  wp, wp_nxt, rp_s;
    logic [FCW-1:0] fcnt, fcnt_nxt;
    int             fill;
    logic           is_frame;

    assign rp_s     = g2ptr(rp_gray_s);
    assign is_frame = (din == FILL_WORD);

    always_comb begin
        fill = int'(wp) - int'(rp_s);
        if (fill < 0) fill = fill + TWO_D;
    end

    // next-state selection, in priority order
    always_comb begin
        if (bypass)                           nxt = WS_HOLD;
        else if (is_frame && fill >= HI_MARK) nxt = WS_DROP;
        else if (fill >= DEPTH)               nxt = WS_RECENTRE;
        else                                  nxt = WS_STORE;
    end

    // pointer and counter effect of the chosen action
    always_comb begin
        wp_nxt   = wp;
        fcnt_nxt = fcnt;
        unique case (nxt)
            WS_STORE: begin
                wp_nxt = ptr_add(wp, 1);
                if (is_frame) fcnt_nxt = fcnt + 1'b1;
            end
            WS_RECENTRE: wp_nxt = ptr_add(rp_s, MID);
            WS_DROP, WS_HOLD: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= WS_HOLD;
            wp       <= PW'(MID);
            wp_gray  <= ptr2g(PW'(MID));
            fcnt     <= FCW'(MID);
            frm_gray <= FCW'(MID) ^ (FCW'(MID) >> 1);
            ovf_err  <= 1'b0;
        end else begin
            state    <= nxt;
            wp       <= wp_nxt;
            wp_gray  <= ptr2g(wp_nxt);
            fcnt     <= fcnt_nxt;
            frm_gray <= fcnt_nxt ^ (fcnt_nxt >> 1);
            if (nxt == WS_RECENTRE) ovf_err <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        we        = (nxt == WS_STORE);
        waddr     = (int'(wp) >= DEPTH) ? AW'(int'(wp) - DEPTH) : AW'(wp);
        wdata     = din;
        del_pulse = (state == WS_DROP);
    end

endmodule

// File: rtl/rxeb_rd_ctl.sv
module rxeb_rd_ctl
    import rxeb_pkg::*;
#(
    parameter int DEPTH   = 10,
    parameter int MID     = 5,
    parameter int LO_MARK = 2,
    parameter int PW      = 5,
    parameter int FCW     = 5,
    localparam int AW     = $clog2(DEPTH),
    localparam int TWO_D  = 2 * DEPTH,
    localparam int GOFS   = (1 << (PW - 1)) - DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bypass,
    input  logic [PW-1:0]  wp_gray_s,
    input  logic [FCW-1:0] frm_gray_s,
    input  word_t          mem_rdata,
    output logic [PW-1:0]  rp_gray,
    output logic [AW-1:0]  raddr,
    output word_t          dout,
    output logic           ins_pulse,
    output logic           udf_err
);

    function automatic logic [PW-1:0] ptr2g(input logic [PW-1:0] p);
        logic [7:0] t;
        t = bin2gray(8'(32'(p) + 32'(GOFS)));
        return t[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] g2ptr(input logic [PW-1:0] g);
        logic [7:0] t;
        t = gray2bin(8'(g));
        return PW'(32'(t) - 32'(GOFS));
    endfunction

    function automatic logic [PW-1:0] ptr_add(input logic [PW-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= TWO_D) s = s - TWO_D;
        if (s < 0)      s = s + TWO_D;
        return PW'(s);
    endfunction

    rd_state_e      state, nxt;
    logic [PW-1:0]  rp, rp_nxt, wp_s;
    logic [FCW-1:0] frd, frd_nxt, fwr_s, fdiff;
    logic [7:0]     fwr_t;
    logic           frame_held;
    int             fill;

    assign wp_s       = g2ptr(wp_gray_s);
    assign fwr_t      = gray2bin(8'(frm_gray_s));
    assign fwr_s      = fwr_t[FCW-1:0];
    assign fdiff      = fwr_s - frd;
    assign frame_held = (fdiff != '0) && !fdiff[FCW-1];

    always_comb begin
        fill = int'(wp_s) - int'(rp);
        if (fill < 0) fill = fill + TWO_D;
    end

    // next-state selection, in priority order
    always_comb begin
        if (bypass)                              nxt = RS_HOLD;
        else if (fill <= LO_MARK && frame_held)  nxt = RS_FILL;
        else if (fill == 0)                      nxt = RS_RECENTRE;
        else                                     nxt = RS_FETCH;
    end

    always_comb begin
        rp_nxt  = rp;
        frd_nxt = frd;
        unique case (nxt)
            RS_FETCH: begin
                rp_nxt = ptr_add(rp, 1);
                if (mem_rdata == FILL_WORD) frd_nxt = frd + 1'b1;
            end
            RS_RECENTRE: rp_nxt = ptr_add(wp_s, -MID);
            RS_FILL, RS_HOLD: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= RS_HOLD;
            rp      <= '0;
            rp_gray <= ptr2g('0);
            frd     <= '0;
            dout    <= FILL_WORD;
            udf_err <= 1'b0;
        end else begin
            state   <= nxt;
            rp      <= rp_nxt;
            rp_gray <= ptr2g(rp_nxt);
            frd     <= frd_nxt;
            unique case (nxt)
                RS_FETCH:    dout <= mem_rdata;
                RS_FILL:     dout <= FILL_WORD;
                RS_RECENTRE: begin
                    dout    <= FILL_WORD;
                    udf_err <= 1'b1;
                end
                RS_HOLD:     dout <= dout;
            endcase
        end
    end

    // outputs
    always_comb begin
        raddr     = (int'(rp) >= DEPTH) ? AW'(int'(rp) - DEPTH) : AW'(rp);
        ins_pulse = (state == RS_FILL);
    end

endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
    import rxeb_pkg::*;
#(
    parameter int DEPTH   = 10,
    parameter int MID     = 5,
    parameter int LO_MARK = 2,
    parameter int HI_MARK = 8,
    parameter int FCW     = 5
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              bypass,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_ins,
    output logic              wr_del,
    output logic              wr_err,
    output logic              rd_err
);

    localparam int PW   = $clog2(2 * DEPTH);
    localparam int AW   = $clog2(DEPTH);
    localparam int GOFS = (1 << (PW - 1)) - DEPTH;

    localparam logic [7:0]     RP_G8 = bin2gray(8'(GOFS));
    localparam logic [7:0]     WP_G8 = bin2gray(8'(GOFS + MID));
    localparam logic [7:0]     FC_G8 = bin2gray(8'(MID));
    localparam logic [PW-1:0]  RP_G0 = RP_G8[PW-1:0];
    localparam logic [PW-1:0]  WP_G0 = WP_G8[PW-1:0];
    localparam logic [FCW-1:0] FC_G0 = FC_G8[FCW-1:0];

    logic [PW-1:0]  wp_gray, wp_gray_s, rp_gray, rp_gray_s;
    logic [FCW-1:0] frm_gray, frm_gray_s;
    logic           we;
    logic [AW-1:0]  waddr, raddr;
    word_t          wdata, mem_rdata, fifo_dout, byp_q;

    rxeb_sync #(.W(PW), .RST_VAL(RP_G0)) u_sync_rp (
        .clk(wr_clk), .rst_n(rst_n), .d(rp_gray), .q(rp_gray_s)
    );

    rxeb_sync #(.W(PW), .RST_VAL(WP_G0)) u_sync_wp (
        .clk(rd_clk), .rst_n(rst_n), .d(wp_gray), .q(wp_gray_s)
    );

    rxeb_sync #(.W(FCW), .RST_VAL(FC_G0)) u_sync_frm (
        .clk(rd_clk), .rst_n(rst_n), .d(frm_gray), .q(frm_gray_s)
    );

    rxeb_wr_ctl #(
        .DEPTH(DEPTH), .MID(MID), .HI_MARK(HI_MARK), .PW(PW), .FCW(FCW)
    ) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .bypass(bypass), .din(wr_data),
        .rp_gray_s(rp_gray_s), .wp_gray(wp_gray), .frm_gray(frm_gray),
        .we(we), .waddr(waddr), .wdata(wdata),
        .del_pulse(wr_del), .ovf_err(wr_err)
    );

    rxeb_store #(.DEPTH(DEPTH)) u_store (
        .clk(wr_clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(mem_rdata)
    );

    rxeb_rd_ctl #(
        .DEPTH(DEPTH), .MID(MID), .LO_MARK(LO_MARK), .PW(PW), .FCW(FCW)
    ) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .bypass(bypass),
        .wp_gray_s(wp_gray_s), .frm_gray_s(frm_gray_s), .mem_rdata(mem_rdata),
        .rp_gray(rp_gray), .raddr(raddr), .dout(fifo_dout),
        .ins_pulse(rd_ins), .udf_err(rd_err)
    );

    // pass-through register for recovered-clock output mode
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) byp_q <= FILL_WORD;
        else        byp_q <= wr_data;
    end

    assign rd_data = bypass ? byp_q : fifo_dout;

endmodule

// File: rtl/rx_elastic_buf_chk.sv
module rx_elastic_buf_chk
    import rxeb_pkg::*;
(
    input logic              wr_clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] wr_data,
    input logic              rd_clk,
    input logic              bypass,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_ins,
    input logic              wr_del,
    input logic              wr_err,
    input logic              rd_err
);

    AST_DROP_FRAME_ONLY: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_del |-> $past(wr_data) == FILL_WORD);                            // R4

    AST_INS_IS_FILL: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_ins |-> rd_data == FILL_WORD);                                   // R5

    AST_BYPASS_NO_DEL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (bypass && $past(bypass)) |-> !wr_del);                             // R9

    AST_BYPASS_NO_INS: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (bypass && $past(bypass)) |-> !rd_ins);                             // R9

    AST_BYPASS_DATA: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (bypass && $past(bypass) && $past(rst_n)) |-> rd_data == $past(wr_data)); // R9

    AST_WR_ERR_STICKY: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_err |=> wr_err);                                                 // R7

    AST_RD_ERR_STICKY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_err |=> rd_err);                                                 // R8

endmodule

bind rx_elastic_buf rx_elastic_buf_chk u_chk (.*);

// File: tb/rx_elastic_buf_test.sv
`timescale 1ns/10ps
module rx_elastic_buf_test;
    import rxeb_pkg::*;

    logic  wr_clk, rd_clk, rst_n, bypass;
    word_t wr_data, rd_data;
    logic  rd_ins, wr_del, wr_err, rd_err;

    rx_elastic_buf uut (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_data(wr_data), .rd_clk(rd_clk),
        .bypass(bypass), .rd_data(rd_data), .rd_ins(rd_ins), .wr_del(wr_del),
        .wr_err(wr_err), .rd_err(rd_err)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    real   wr_half  = 2.5;
    int    frame_every = 4;
    int    wr_cnt   = 0;
    int    n_ins    = 0;
    int    n_del    = 0;
    bit    model_ok = 0;
    bit    done     = 0;
    logic  wr_live  = 0;
    logic  rd_live  = 0;
    word_t q [$];

    // 200 MHz read clock
    initial begin
        rd_clk = 0;
        forever #2.5 rd_clk = ~rd_clk;
    end

    initial begin
        wr_clk = 0;
        #1.1;
        forever begin
            #(wr_half) wr_clk = ~wr_clk;
        end
    end

    always @(posedge wr_clk) wr_live <= rst_n;
    always @(posedge rd_clk) rd_live <= rst_n;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit q_has_fill();
        foreach (q[i]) if (q[i] == FILL_WORD) return 1;
        return 0;
    endfunction

    // write side: observe last edge, then drive next word
    initial begin
        wr_data = FILL_WORD;
        forever begin
            @(negedge wr_clk);
            if (wr_live && bypass) begin
                check(rd_data == wr_data, "R9", "bypass data", 32'(rd_data), 32'(wr_data));
                check(!wr_del && !rd_ins, "R9", "bypass flags", {30'd0, wr_del, rd_ins}, 0);
            end else if (wr_live && model_ok) begin
                if (wr_err) begin
                    model_ok = 0;
                end else if (wr_del) begin
                    n_del++;
                    check(wr_data == FILL_WORD, "R4", "dropped word", 32'(wr_data), 32'(FILL_WORD));
                end else begin
                    q.push_back(wr_data);
                end
            end
            wr_cnt++;
            if (frame_every != 0 && (wr_cnt % frame_every) == 0) wr_data = FILL_WORD;
            else wr_data = {3'b000, 8'(wr_cnt)};
        end
    end

    // read side: reference queue compared every read cycle
    initial begin
        forever begin
            word_t exp;
            @(negedge rd_clk);
            if (rd_live && !bypass && model_ok) begin
                if (rd_err) begin
                    model_ok = 0;
                end else if (rd_ins) begin
                    n_ins++;
                    check(rd_data == FILL_WORD, "R5", "inserted word", 32'(rd_data), 32'(FILL_WORD));
                    check(q_has_fill(), "R6", "framing word held at insert", 0, 1);
                end else begin
                    check(q.size() > 0, "R8", "read from empty model", 32'(q.size()), 1);
                    if (q.size() > 0) begin
                        exp = q.pop_front();
                        check(rd_data == exp, "R1 R2", "stream order", 32'(rd_data), 32'(exp));
                    end
                end
            end
        end
    end

    task automatic start_phase(input bit byp, input real half, input int every);
        rst_n = 0;
        repeat (3) @(posedge rd_clk);
        wr_half     = half;
        bypass      = byp;
        frame_every = every;
        repeat (3) @(posedge rd_clk);
        q.delete();
        if (!byp) repeat (5) q.push_back(FILL_WORD);
        n_ins = 0;
        n_del = 0;
        model_ok = 1;
        #1;
        // R2: state held during reset
        check(!rd_ins && !wr_del, "R2", "flags in reset", {30'd0, rd_ins, wr_del}, 0);
        check(!wr_err && !rd_err, "R2", "errors in reset", {30'd0, wr_err, rd_err}, 0);
        if (!byp) check(rd_data == FILL_WORD, "R2", "rd_data in reset", 32'(rd_data), 32'(FILL_WORD));
        @(negedge rd_clk);
        #0.05;
        rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n  = 0;
        bypass = 0;

        // equal rates, framing words present
        start_phase(0, 2.5, 4);
        repeat (400) @(posedge rd_clk);
        check(!wr_err, "R7", "no overflow at equal rate", 32'(wr_err), 0);
        check(!rd_err, "R8", "no underflow at equal rate", 32'(rd_err), 0);

        // write faster: deletions expected
        start_phase(0, 2.4, 4);
        repeat (800) @(posedge rd_clk);
        check(n_del > 0, "R3", "deletions seen", 32'(n_del), 1);
        check(!wr_err && !rd_err, "R7", "no error while deleting", {30'd0, wr_err, rd_err}, 0);

        // read faster: insertions expected
        start_phase(0, 2.6, 4);
        repeat (800) @(posedge rd_clk);
        check(n_ins > 0, "R5", "insertions seen", 32'(n_ins), 1);
        check(!wr_err && !rd_err, "R8", "no error while inserting", {30'd0, wr_err, rd_err}, 0);

        // write faster, no framing words: overflow
        start_phase(0, 2.4, 0);
        repeat (600) @(posedge rd_clk);
        check(wr_err, "R7", "overflow flag", 32'(wr_err), 1);
        check(n_del == 0, "R4", "no deletion without framing", 32'(n_del), 0);

        // read faster, no framing words: underflow
        start_phase(0, 2.6, 0);
        repeat (800) @(posedge rd_clk);
        check(rd_err, "R8", "underflow flag", 32'(rd_err), 1);

        // bypass mode
        start_phase(1, 2.5, 4);
        repeat (100) @(posedge rd_clk);
        check(!wr_err && !rd_err, "R9", "no error in bypass", {30'd0, wr_err, rd_err}, 0);

        finish_run();
    end

endmodule